// File: doc/BRIEF.md
# Edwards-Curve Ladder Microprogram Sequencer

This block steps an external dual-bank modular arithmetic datapath through a complete scalar point multiplication on a twisted Edwards curve. It holds no field data of its own. It issues one micro-operation at a time and waits for the datapath to report completion. Each micro-operation carries an opcode, a source bank, two source slot numbers, a destination bank, a destination slot and a modulus choice.

A start pulse loads a scalar. The two top bits of the scalar are forced to a fixed value before use. The sequencer first sets up two ladder points. It then runs one ladder round per scalar bit, from the most significant bit down to bit 0. Each round copies the two points into working slots in an order set by the bit. It then runs a fixed doubling-and-addition body and writes the result back to one of the two points.

After the last round, the sequencer stages the Z coordinate for an external field-inversion routine and hands control to that routine through a call/return handshake. It then scales X and Y by the inverse and fully reduces both. Last, it merges the parity of X into the top bit of the most significant output word of Y, issues the output moves and signals completion.

Top module: `edw_ladder_seq`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) leaves the block idle: uop_valid, inv_call and finished are all 0 from the next cycle on.
- R2: In idle, a start pulse latches the scalar with bit KW-1 forced to 0 and bit KW-2 forced to 1. The block then runs exactly KW rounds, and round r uses bit KW-1-r of that latched value.
- R3: Opcodes are MOVE=0, ADD=1, SUB=2, MUL=3. Bank LO=0 and HI=1. Modulus 2P=0 and 1P=1. Once uop_valid is raised, it and all uop fields stay unchanged until uop_done is seen at a clock edge. Only after that may the next uop appear. A MOVE carries its single source in both source slot fields.
- R4: Every uop reads from one bank and writes to the other (uop_src_bank differs from uop_dst_bank).
- R5: Slot map: point R0 uses slots 8..11 and R1 uses 12..15, each in the order X, Y, Z, T. Constants sit in HI slots 0 (zero), 1 (one), 2 (base X), 3 (base Y) and 4 (base T). Setup is 8 MOVEs from HI to LO. R0 X,Y,Z,T receive constants 0,1,1,0. R1 X,Y,Z,T receive constants 2,3,1,4.
- R6: Each round begins with 8 MOVEs from LO to HI. The first four fill U (HI 16..19) and the next four fill V (HI 20..23), coordinate by coordinate. U comes from R0 when the round bit is 1 and from R1 when it is 0. V comes from the other point.
- R7: Each round then runs a 34-uop body, all with 2P modulus, in which only the 11th and 12th uops are MOVEs. It ends with 4 MOVEs from HI slots 28..31 (T) into R0 when the bit is 1, or into R1 when it is 0.
- R8: After the last round, R0.Z is moved LO to HI (slot 10) and then HI slot 10 to LO slot 48. Then inv_call rises and stays high until inv_ret. No uop is valid while inv_call is high.
- R9: After the inversion returns, the block issues these uops in order:
  - MOVE HI 49 to LO 49.
  - MUL LO (49, 8) to HI 8.
  - MUL LO (49, 9) to HI 9.
  - ADD HI (8, 0) to LO 8 with 1P.
  - ADD HI (9, 0) to LO 9 with 1P.
  - MOVE LO 8 to HI 8.
  - MOVE LO 9 to HI 9.

  The two reduction ADDs are the only uops ever issued with 1P.
- R10: y_msw_out takes the value y_msw OR (x_lsb shifted to bit WW-1), sampled in the cycle the second reduction ADD completes, and holds it afterwards.
- R11: A run issues exactly 8 + 46*KW + 9 uops. finished is high for exactly one cycle, in the cycle after the last uop's done.
- R12: A start pulse while a run is in progress has no effect on the issued uop stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run (honoured only in idle) |
| scalar | input | KW | Multiplier, latched at start |
| uop_valid | output | 1 | A uop is being presented |
| uop_op | output | 2 | Opcode: MOVE, ADD, SUB, MUL |
| uop_src_bank | output | 1 | Bank both operands are read from |
| uop_src_a | output | SW | First source slot |
| uop_src_b | output | SW | Second source slot |
| uop_dst_bank | output | 1 | Bank the result is written to |
| uop_dst | output | SW | Destination slot |
| uop_mod | output | 1 | Modulus choice: 0 = 2P, 1 = 1P |
| uop_done | input | 1 | Datapath has completed the presented uop |
| inv_call | output | 1 | Request to the inversion routine |
| inv_ret | input | 1 | Inversion routine has finished |
| x_lsb | input | 1 | Bit 0 of the reduced X, from the datapath |
| y_msw | input | WW | Most significant word of the reduced Y, from the datapath |
| y_msw_out | output | WW | Y top word with the X parity merged into its top bit |
| finished | output | 1 | One-cycle completion pulse |

## Verification
A wrong round bit or a stray bit-counter step shows up in the first uop of the affected round. That uop names R1 where R0 was due, or the reverse, within one uop of the fault. It shows again four uops before the round ends, when T is written back to the wrong point. A slip in the segment position changes the total uop count and moves the inversion call and the finish pulse, so it is visible by the end of the run at the latest. A missed or extra completion wait appears in the cycle after it happens, as uop fields changing while done is still low.

// File: rtl/edw_ladder_seq.sv
module edw_ladder_seq #(
  parameter int KW = 256,
  parameter int WW = 32,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [KW-1:0] scalar,
  output logic          uop_valid,
  output logic [1:0]    uop_op,
  output logic          uop_src_bank,
  output logic [SW-1:0] uop_src_a,
  output logic [SW-1:0] uop_src_b,
  output logic          uop_dst_bank,
  output logic [SW-1:0] uop_dst,
  output logic          uop_mod,
  input  logic          uop_done,
  output logic          inv_call,
  input  logic          inv_ret,
  input  logic          x_lsb,
  input  logic [WW-1:0] y_msw,
  output logic [WW-1:0] y_msw_out,
  output logic          finished
);
  localparam int BW = $clog2(KW);
  localparam int UW = 3*SW + 5;

  localparam logic [1:0] OP_MOVE = 2'd0, OP_ADD = 2'd1, OP_SUB = 2'd2, OP_MUL = 2'd3;
  localparam logic LO = 1'b0, HI = 1'b1;

  localparam logic [SW-1:0] K0 = SW'(0), K1 = SW'(1), KGX = SW'(2), KGY = SW'(3), KGT = SW'(4);
  localparam logic [SW-1:0] P0 = SW'(8), P1 = SW'(12), PU = SW'(16), PV = SW'(20), PS = SW'(24), PT = SW'(28);
  localparam logic [SW-1:0] P0X = SW'(8), P0Y = SW'(9), P0Z = SW'(10);
  localparam logic [SW-1:0] UX = SW'(16), UY = SW'(17), UZ = SW'(18);
  localparam logic [SW-1:0] VX = SW'(20), VY = SW'(21), VZ = SW'(22), VT = SW'(23);
  localparam logic [SW-1:0] SX = SW'(24), SY = SW'(25), SZ = SW'(26), ST = SW'(27);
  localparam logic [SW-1:0] TX = SW'(28), TY = SW'(29), TZ = SW'(30), TT = SW'(31);
  localparam logic [SW-1:0] WA = SW'(32), WB = SW'(33), WC = SW'(34), WD = SW'(35), WE = SW'(36);
  localparam logic [SW-1:0] WF = SW'(37), WG = SW'(38), WH = SW'(39), WI = SW'(40), WJ = SW'(41);
  localparam logic [SW-1:0] INV_IN = SW'(48), INV_OUT = SW'(49);

  typedef enum logic [3:0] {
    S_IDLE, S_PREP, S_PICK, S_BODY, S_PLACE, S_PREINV, S_INV,
    S_POSTINV, S_REDUCE, S_SIGN, S_OUT, S_FIN
  } seg_t;

  seg_t          seg, nxt;
  logic [5:0]    idx;
  logic [BW-1:0] bitn;
  logic [KW-1:0] kreg, kmask;
  logic          kb, last;
  logic [UW-1:0] word;

  function automatic logic [UW-1:0] mk(input logic [1:0] op, input logic sb,
      input logic [SW-1:0] a, input logic [SW-1:0] b, input logic [SW-1:0] d, input logic m);
    return {op, sb, a, b, ~sb, d, m};
  endfunction

  function automatic logic [UW-1:0] mv(input logic sb, input logic [SW-1:0] a, input logic [SW-1:0] d);
    return mk(OP_MOVE, sb, a, a, d, 1'b0);
  endfunction

  function automatic logic [5:0] seg_len(input seg_t s);
    case (s)
      S_PREP, S_PICK: return 6'd8;
      S_BODY:         return 6'd34;
      S_PLACE:        return 6'd4;
      S_PREINV:       return 6'd2;
      S_POSTINV:      return 6'd3;
      S_REDUCE:       return 6'd2;
      default:        return 6'd1;
    endcase
  endfunction

  function automatic logic [UW-1:0] rom(input seg_t s, input logic [5:0] i, input logic b);
    logic [SW-1:0] c;
    c = SW'(i[1:0]);
    rom = '0;
    case (s)
      S_PREP: case (i[2:0])
        3'd0: rom = mv(HI, K0,  P0 + SW'(0));
        3'd1: rom = mv(HI, K1,  P0 + SW'(1));
        3'd2: rom = mv(HI, K1,  P0 + SW'(2));
        3'd3: rom = mv(HI, K0,  P0 + SW'(3));
        3'd4: rom = mv(HI, KGX, P1 + SW'(0));
        3'd5: rom = mv(HI, KGY, P1 + SW'(1));
        3'd6: rom = mv(HI, K1,  P1 + SW'(2));
        default: rom = mv(HI, KGT, P1 + SW'(3));
      endcase
      S_PICK:  rom = mv(LO, ((b ^ i[2]) ? P0 : P1) + c, (i[2] ? PV : PU) + c);
      S_BODY: case (i)
        6'd0:  rom = mk(OP_MUL, HI, UX, UX, WA, 1'b0);
        6'd1:  rom = mk(OP_MUL, HI, UY, UY, WB, 1'b0);
        6'd2:  rom = mk(OP_MUL, HI, UZ, UZ, WI, 1'b0);
        6'd3:  rom = mk(OP_ADD, LO, WI, WI, WC, 1'b0);
        6'd4:  rom = mk(OP_ADD, HI, UX, UY, WI, 1'b0);
        6'd5:  rom = mk(OP_MUL, LO, WI, WI, WD, 1'b0);
        6'd6:  rom = mk(OP_ADD, LO, WA, WB, WH, 1'b0);
        6'd7:  rom = mk(OP_SUB, HI, WH, WD, WE, 1'b0);
        6'd8:  rom = mk(OP_SUB, LO, WA, WB, WG, 1'b0);
        6'd9:  rom = mk(OP_ADD, HI, WC, WG, WF, 1'b0);
        6'd10: rom = mv(HI, WG, WG);
        6'd11: rom = mv(HI, WH, WH);
        6'd12: rom = mk(OP_MUL, LO, WE, WF, SX, 1'b0);
        6'd13: rom = mk(OP_MUL, LO, WG, WH, SY, 1'b0);
        6'd14: rom = mk(OP_MUL, LO, WE, WH, ST, 1'b0);
        6'd15: rom = mk(OP_MUL, LO, WF, WG, SZ, 1'b0);
        6'd16: rom = mk(OP_SUB, HI, SY, SX, WI, 1'b0);
        6'd17: rom = mk(OP_ADD, HI, VY, VX, WJ, 1'b0);
        6'd18: rom = mk(OP_MUL, LO, WI, WJ, WA, 1'b0);
        6'd19: rom = mk(OP_ADD, HI, SY, SX, WI, 1'b0);
        6'd20: rom = mk(OP_SUB, HI, VY, VX, WJ, 1'b0);
        6'd21: rom = mk(OP_MUL, LO, WI, WJ, WB, 1'b0);
        6'd22: rom = mk(OP_MUL, HI, SZ, VT, WI, 1'b0);
        6'd23: rom = mk(OP_ADD, LO, WI, WI, WC, 1'b0);
        6'd24: rom = mk(OP_MUL, HI, ST, VZ, WI, 1'b0);
        6'd25: rom = mk(OP_ADD, LO, WI, WI, WD, 1'b0);
        6'd26: rom = mk(OP_ADD, HI, WC, WD, WE, 1'b0);
        6'd27: rom = mk(OP_SUB, HI, WB, WA, WF, 1'b0);
        6'd28: rom = mk(OP_ADD, HI, WB, WA, WG, 1'b0);
        6'd29: rom = mk(OP_SUB, HI, WD, WC, WH, 1'b0);
        6'd30: rom = mk(OP_MUL, LO, WE, WF, TX, 1'b0);
        6'd31: rom = mk(OP_MUL, LO, WG, WH, TY, 1'b0);
        6'd32: rom = mk(OP_MUL, LO, WE, WH, TT, 1'b0);
        default: rom = mk(OP_MUL, LO, WF, WG, TZ, 1'b0);
      endcase
      S_PLACE:  rom = mv(HI, PT + c, (b ? P0 : P1) + c);
      S_PREINV: rom = i[0] ? mv(HI, P0Z, INV_IN) : mv(LO, P0Z, P0Z);
      S_POSTINV: case (i[1:0])
        2'd0:    rom = mv(HI, INV_OUT, INV_OUT);
        2'd1:    rom = mk(OP_MUL, LO, INV_OUT, P0X, P0X, 1'b0);
        default: rom = mk(OP_MUL, LO, INV_OUT, P0Y, P0Y, 1'b0);
      endcase
      S_REDUCE: rom = i[0] ? mk(OP_ADD, HI, P0Y, K0, P0Y, 1'b1) : mk(OP_ADD, HI, P0X, K0, P0X, 1'b1);
      S_SIGN:   rom = mv(LO, P0X, P0X);
      S_OUT:    rom = mv(LO, P0Y, P0Y);
      default:  rom = '0;
    endcase
  endfunction

  always_comb begin
    kmask = scalar;
    kmask[KW-1] = 1'b0;
    kmask[KW-2] = 1'b1;
  end

  assign kb   = kreg[bitn];
  assign last = (idx == seg_len(seg) - 6'd1);
  assign word = rom(seg, idx, kb);

  assign uop_valid = !(seg inside {S_IDLE, S_INV, S_FIN});
  assign {uop_op, uop_src_bank, uop_src_a, uop_src_b, uop_dst_bank, uop_dst, uop_mod} = word;
  assign inv_call = (seg == S_INV);
  assign finished = (seg == S_FIN);

  always_comb begin
    case (seg)
      S_PREP:    nxt = S_PICK;
      S_PICK:    nxt = S_BODY;
      S_BODY:    nxt = S_PLACE;
      S_PLACE:   nxt = (bitn == '0) ? S_PREINV : S_PICK;
      S_PREINV:  nxt = S_INV;
      S_POSTINV: nxt = S_REDUCE;
      S_REDUCE:  nxt = S_SIGN;
      S_SIGN:    nxt = S_OUT;
      S_OUT:     nxt = S_FIN;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg       <= S_IDLE;
      idx       <= '0;
      bitn      <= '0;
      kreg      <= '0;
      y_msw_out <= '0;
    end else begin
      case (seg)
        S_IDLE: if (start) begin
          kreg <= kmask;
          bitn <= BW'(KW-1);
          idx  <= '0;
          seg  <= S_PREP;
        end
        S_INV: if (inv_ret) seg <= S_POSTINV;
        S_FIN: seg <= S_IDLE;
        default: if (uop_done) begin
          if (!last) idx <= idx + 6'd1;
          else begin
            idx <= '0;
            seg <= nxt;
            if (seg == S_PLACE && bitn != '0) bitn <= bitn - BW'(1);
            if (seg == S_REDUCE) y_msw_out <= y_msw | {x_lsb, {(WW-1){1'b0}}};
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/edw_ladder_seq_chk.sv
module edw_ladder_seq_chk #(
  parameter int SW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          uop_valid,
  input logic [1:0]    uop_op,
  input logic          uop_src_bank,
  input logic [SW-1:0] uop_src_a,
  input logic [SW-1:0] uop_src_b,
  input logic          uop_dst_bank,
  input logic [SW-1:0] uop_dst,
  input logic          uop_mod,
  input logic          uop_done,
  input logic          inv_call,
  input logic          inv_ret,
  input logic          finished
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!uop_valid && !inv_call && !finished));

  // R3
  uop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && !uop_done) |=> (uop_valid && $stable({uop_op, uop_src_bank, uop_src_a, uop_src_b, uop_dst_bank, uop_dst, uop_mod})));

  // R4
  bank_swap_chk: assert property (@(posedge clk) disable iff (rst)
    uop_valid |-> (uop_src_bank != uop_dst_bank));

  // R8
  inv_excl_chk: assert property (@(posedge clk) disable iff (rst) !(inv_call && uop_valid));

  // R8
  inv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_call && !inv_ret) |=> inv_call);

  // R8
  inv_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(inv_call) |-> $past(uop_valid && uop_done));

  // R9
  full_mod_chk: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && uop_mod) |-> (uop_op == 2'd1));

  // R11
  fin_pulse_chk: assert property (@(posedge clk) disable iff (rst) finished |=> !finished);

  // R11
  fin_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(finished) |-> $past(uop_valid && uop_done));
endmodule

bind edw_ladder_seq edw_ladder_seq_chk #(.SW(SW)) chk_i (
  .clk(clk), .rst(rst), .uop_valid(uop_valid), .uop_op(uop_op),
  .uop_src_bank(uop_src_bank), .uop_src_a(uop_src_a), .uop_src_b(uop_src_b),
  .uop_dst_bank(uop_dst_bank), .uop_dst(uop_dst), .uop_mod(uop_mod),
  .uop_done(uop_done), .inv_call(inv_call), .inv_ret(inv_ret), .finished(finished)
);

// File: tb/edw_ladder_seq_tb_top.sv
`timescale 1ns/1ps
module edw_ladder_seq_tb_top;
  localparam int KW = 32;
  localparam int WW = 32;
  localparam int SW = 6;
  localparam int NR = 8 + 46*KW;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [KW-1:0] scalar = '0;
  logic uop_valid, uop_src_bank, uop_dst_bank, uop_mod, inv_call, finished;
  logic [1:0] uop_op;
  logic [SW-1:0] uop_src_a, uop_src_b, uop_dst;
  logic uop_done = 1'b0, inv_ret = 1'b0, x_lsb = 1'b0;
  logic [WW-1:0] y_msw = '0, y_msw_out;

  always #2.5 clk = ~clk;

  edw_ladder_seq #(.KW(KW), .WW(WW), .SW(SW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .scalar(scalar),
    .uop_valid(uop_valid), .uop_op(uop_op), .uop_src_bank(uop_src_bank),
    .uop_src_a(uop_src_a), .uop_src_b(uop_src_b), .uop_dst_bank(uop_dst_bank),
    .uop_dst(uop_dst), .uop_mod(uop_mod), .uop_done(uop_done),
    .inv_call(inv_call), .inv_ret(inv_ret), .x_lsb(x_lsb), .y_msw(y_msw),
    .y_msw_out(y_msw_out), .finished(finished)
  );

  int total = 0, bad = 0;
  int n, e_bank, e_prep, e_sel, e_body, e_place, e_tail, e_hold;
  int inv_cnt, inv_at, fin_cnt, fin_at, dly = 0, iw = 0;
  bit was_wait = 0, over = 0;
  logic [KW-1:0] mexp;
  logic [3*SW+4:0] prev;

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int prep_src(input int i);
    case (i)
      0: return 0; 1: return 1; 2: return 1; 3: return 0;
      4: return 2; 5: return 3; 6: return 1; default: return 4;
    endcase
  endfunction

  function automatic bit tail_ok(input int t);
    int op, sb, a, b, d, m;
    case (t)
      0: begin op=0; sb=0; a=10; b=10; d=10; m=0; end
      1: begin op=0; sb=1; a=10; b=10; d=48; m=0; end
      2: begin op=0; sb=1; a=49; b=49; d=49; m=0; end
      3: begin op=3; sb=0; a=49; b=8;  d=8;  m=0; end
      4: begin op=3; sb=0; a=49; b=9;  d=9;  m=0; end
      5: begin op=1; sb=1; a=8;  b=0;  d=8;  m=1; end
      6: begin op=1; sb=1; a=9;  b=0;  d=9;  m=1; end
      7: begin op=0; sb=0; a=8;  b=8;  d=8;  m=0; end
      8: begin op=0; sb=0; a=9;  b=9;  d=9;  m=0; end
      default: return 0;
    endcase
    return (uop_op == op && uop_src_bank == sb && uop_src_a == a && uop_src_b == b &&
            uop_dst == d && uop_mod == m);
  endfunction

  task automatic rec();
    int r, k, c, es;
    logic kb;
    if (uop_src_bank == uop_dst_bank) e_bank++;
    if (n < 8) begin
      if (uop_op != 0 || uop_src_bank != 1 || uop_src_a != prep_src(n) ||
          uop_dst != 8 + n || uop_mod != 0) e_prep++;
    end else if (n < NR) begin
      r = (n - 8) / 46;
      k = (n - 8) % 46;
      kb = mexp[KW-1-r];
      if (k < 8) begin
        c = k % 4;
        es = (((k < 4) ? 1'b1 : 1'b0) == kb) ? 8 + c : 12 + c;
        if (uop_op != 0 || uop_src_bank != 0 || uop_src_a != es || uop_src_b != es ||
            uop_dst != ((k < 4) ? 16 : 20) + c || uop_mod != 0) e_sel++;
      end else if (k < 42) begin
        if (uop_mod != 0 || ((uop_op == 0) != (k == 18 || k == 19))) e_body++;
      end else begin
        c = k - 42;
        if (uop_op != 0 || uop_src_bank != 1 || uop_src_a != 28 + c ||
            uop_dst != (kb ? 8 : 12) + c || uop_mod != 0) e_place++;
      end
    end else begin
      if (!tail_ok(n - NR)) e_tail++;
      if ((n - NR < 2 && inv_cnt != 0) || (n - NR >= 2 && inv_cnt != 1)) e_tail++;
    end
    n++;
  endtask

  // datapath and inversion responder
  initial forever begin
    @(negedge clk);
    uop_done = 1'b0;
    inv_ret = 1'b0;
    if (uop_valid) begin
      if (was_wait && prev != {uop_op, uop_src_bank, uop_src_a, uop_src_b, uop_dst_bank, uop_dst, uop_mod})
        e_hold++;
      if (dly == 0) begin
        rec();
        uop_done = 1'b1;
        was_wait = 0;
        dly = n % 3;
      end else begin
        dly--;
        was_wait = 1;
        prev = {uop_op, uop_src_bank, uop_src_a, uop_src_b, uop_dst_bank, uop_dst, uop_mod};
      end
    end else was_wait = 0;
    if (inv_call) begin
      iw++;
      if (iw == 4) begin
        inv_ret = 1'b1;
        inv_cnt++;
        inv_at = n;
        iw = 0;
      end
    end
    if (finished) begin
      fin_cnt++;
      fin_at = n;
    end
  end

  task automatic clear_stats();
    n = 0; e_bank = 0; e_prep = 0; e_sel = 0; e_body = 0; e_place = 0; e_tail = 0; e_hold = 0;
    inv_cnt = 0; inv_at = -1; fin_cnt = 0; fin_at = -1;
  endtask

  task automatic run(input logic [KW-1:0] sc, input logic xl, input logic [WW-1:0] ym, input bit disturb);
    int cyc;
    clear_stats();
    mexp = sc;
    mexp[KW-1] = 1'b0;
    mexp[KW-2] = 1'b1;
    scalar = sc;
    x_lsb = xl;
    y_msw = ym;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 0;
    while (fin_cnt == 0 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 400) begin start = 1'b1; scalar = ~sc; end
      else if (disturb && cyc == 401) begin start = 1'b0; scalar = sc; end
    end
    repeat (6) @(negedge clk);
    chk("R11 uop count", n, NR + 9);
    chk("R3 fields held while waiting", e_hold, 0);
    chk("R4 bank alternation", e_bank, 0);
    chk("R5 setup moves", e_prep, 0);
    chk("R6 round select (R2 masked bit order)", e_sel, 0);
    chk("R7 round body", e_body, 0);
    chk("R7 write-back to R0/R1", e_place, 0);
    chk("R8 inversion calls", inv_cnt, 1);
    chk("R8 inversion position", inv_at, NR + 2);
    chk("R9 post-inversion sequence", e_tail, 0);
    chk("R10 merged sign word", y_msw_out, ym | ({31'd0, xl} << (WW-1)));
    chk("R11 finish pulses", fin_cnt, 1);
    chk("R11 finish timing", fin_at, NR + 9);
    if (disturb) chk("R12 busy start ignored", n + e_sel, NR + 9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", uop_valid, 0);
    chk("R1 inv_call in reset", inv_call, 0);
    chk("R1 finished in reset", finished, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", uop_valid, 0);

    run(32'hFFFF_FFFF, 1'b1, 32'h0123_4567, 0);
    run(32'h0000_0000, 1'b0, 32'h8000_0001, 0);
    run(32'hA5A5_3C3C, 1'b1, 32'h7FFF_FFFF, 1);
    run(32'h5555_AAAA, 1'b0, 32'hDEAD_BEEF, 0);

    clear_stats();
    scalar = 32'h1234_5678;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (300) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 valid after mid-run reset", uop_valid, 0);
    chk("R1 inv_call after mid-run reset", inv_call, 0);
    chk("R1 finished after mid-run reset", finished, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 stays idle", uop_valid, 0);

    run(32'h1234_5678, 1'b1, 32'h0000_0000, 0);

    if (!over) begin
      over = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!over) begin
      over = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule